// File: doc/BRIEF.md
# Keyed Fractional Audio Bit-Clock Divider

This block makes an audio bit clock by dividing one of up to sixteen selectable source clocks. The sources arrive as clock-enable strobes in the block's own clock domain, one strobe per source clock cycle. Software programs the block through two 32-bit registers on a plain write/read bus. The control word selects the source, starts and stops the generator, forces an immediate halt, inverts the output and picks the shaping mode. The divisor word holds an integer part and a fractional part. A write to either register lands only when its top byte carries a fixed key, so a stray store cannot retune a running clock.

When the generator starts, each output period lasts the integer divisor in source ticks. The output is high for the first half of the period (rounded down) and low for the rest. With shaping on, a fractional accumulator stretches some periods by one tick, so the long-run average divisor becomes integer plus fraction. Clearing the run bit lets the current period finish and stop low, and a busy flag reports when the generator has really stopped. The halt bit stops it at once. Source, divisor and mode are sampled only while the generator is idle.

Top module: `keyed_frac_clkdiv`

## Requirements
- R1: A write changes the addressed register only when write data bits [31:24] equal 0x5A. With any other key, both registers read back unchanged and the generator does not start.
- R2: The control word reads back as follows: source in [3:0], run in [4], halt in [5], busy in [7], invert in [8] and shaping mode in [10:9]. All other bits read 0, and busy cannot be written.
- R3: The divisor word reads back the integer divisor in [23:12] and the fractional divisor in [11:0]. Bits [31:24] read 0.
- R4: Busy rises on the second clock edge after the keyed write that sets run, provided halt is clear and busy was low. The output is high from that cycle on.
- R5: In shaping mode 0, every output period lasts exactly the effective integer divisor in selected-source ticks. The output is high for the first half of the period, rounded down.
- R6: In any nonzero shaping mode, a 12-bit accumulator adds the fraction at each period boundary. A period that starts with a carry out of the accumulator lasts one extra tick. The first period after start is never stretched.
- R7: An integer divisor of 0 or 1 acts as 2.
- R8: After run is cleared, busy stays high until the current period ends. Busy then falls with the output low, and the output stays low.
- R9: While halt is set, busy is forced low on the next edge, the output goes low, and run cannot start the generator.
- R10: Only the selected source's strobe advances the generator. Source 0 and any index at or above the number of sources never tick.
- R11: Changes to source, divisor or mode made while busy is high have no effect until the generator has stopped and starts again.
- R12: The invert bit XORs the output at all times, including while stopped, and takes effect as soon as it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; source strobes are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel_div | input | 1 | Register select: 0 control word, 1 divisor word |
| bus_wdata | input | 32 | Write data, key in the top byte |
| bus_rdata | output | 32 | Read data of the selected register |
| src_tick | input | NUM_SRC | One clock-enable strobe per source clock |
| clk_out | output | 1 | Divided bit clock, after inversion |

## Verification
The assertions check these properties on every cycle: a halt drops busy on the next edge, busy rises only after run was seen with halt clear, a graceful stop ends with the output low, the sampled configuration stays frozen while busy, and the period length never falls below 2 and stays integer-only in mode 0. The bench's scenarios are needed for behaviour that depends on the tick stream. This covers the exact tick count of each period and of each high phase, the sequence of stretched periods against a model of the fractional accumulator, a source index that never ticks, and a graceful stop that never completes on the ground source until a halt is issued.

// File: rtl/kfcd_pkg.sv
package kfcd_pkg;
   // write key carried in the top byte of every register write
   localparam logic [7:0] WR_KEY   = 8'h5A;
   localparam int         KEY_LSB  = 24;

   // control word field positions (software decodes these)
   localparam int SEL_W    = 4;
   localparam int SRC_LSB  = 0;
   localparam int RUN_BIT  = 4;
   localparam int HALT_BIT = 5;
   localparam int BUSY_BIT = 7;
   localparam int INV_BIT  = 8;
   localparam int MODE_LSB = 9;

   // divisor word: integer part starts here, fraction is LSB aligned
   localparam int INT_LSB  = 12;

   typedef enum logic [1:0] {
      SHP_NONE  = 2'd0,
      SHP_FIRST = 2'd1,
      SHP_ALT2  = 2'd2,
      SHP_ALT3  = 2'd3
   } shape_e;

   typedef struct packed {
      shape_e           mode;
      logic             inv;
      logic             halt;
      logic             run;
      logic [SEL_W-1:0] src;
   } ctrl_t;
endpackage

// File: rtl/kfcd_regs.sv
module kfcd_regs
   import kfcd_pkg::*;
#(
   parameter int         INT_W  = 12,
   parameter int         FRAC_W = 12,
   parameter logic [7:0] KEY    = WR_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_sel_div,
   input  logic [31:0]       bus_wdata,
   input  logic              busy,
   output ctrl_t             ctrl,
   output logic [INT_W-1:0]  int_div,
   output logic [FRAC_W-1:0] frac_div,
   output logic [31:0]       bus_rdata
);
   logic key_ok;
   assign key_ok = (bus_wdata[KEY_LSB +: 8] == KEY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         int_div  <= '0;
         frac_div <= '0;
      end else if (bus_wr && key_ok) begin
         if (!bus_sel_div) begin
            ctrl.src  <= bus_wdata[SRC_LSB +: SEL_W];
            ctrl.run  <= bus_wdata[RUN_BIT];
            ctrl.halt <= bus_wdata[HALT_BIT];
            ctrl.inv  <= bus_wdata[INV_BIT];
            ctrl.mode <= shape_e'(bus_wdata[MODE_LSB +: 2]);
         end else begin
            int_div  <= bus_wdata[INT_LSB +: INT_W];
            frac_div <= bus_wdata[0 +: FRAC_W];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel_div) begin
         bus_rdata[INT_LSB +: INT_W] = int_div;
         bus_rdata[0 +: FRAC_W]      = frac_div;
      end else begin
         bus_rdata[SRC_LSB +: SEL_W] = ctrl.src;
         bus_rdata[RUN_BIT]          = ctrl.run;
         bus_rdata[HALT_BIT]         = ctrl.halt;
         bus_rdata[BUSY_BIT]         = busy;
         bus_rdata[INV_BIT]          = ctrl.inv;
         bus_rdata[MODE_LSB +: 2]    = ctrl.mode;
      end
   end

   // R1: an unkeyed write leaves every stored field alone
   p_keyless_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !key_ok) |=> ($stable(ctrl) && $stable(int_div) && $stable(frac_div)));

   // R2: a keyed control write lands the run bit from the data
   p_keyed_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && key_ok && !bus_sel_div) |=> (ctrl.run == $past(bus_wdata[RUN_BIT])));
endmodule

// File: rtl/kfcd_srcsel.sv
module kfcd_srcsel
   import kfcd_pkg::*;
#(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);
   localparam int SLOTS = 1 << SEL_W;

   logic [SLOTS-1:0] lane;
   logic             unused_gnd;
   assign unused_gnd = src_tick[0];

   // slot 0 is ground, slots beyond the populated sources are dead
   for (genvar i = 0; i < SLOTS; i++) begin : g_lane
      if (i == 0 || i >= NUM_SRC) begin : g_dead
         assign lane[i] = 1'b0;
      end else begin : g_live
         assign lane[i] = src_tick[i];
      end
   end

   assign tick = lane[sel];

   // R10: ground and unpopulated indexes never produce a tick
   p_dead_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel == '0) || (int'(sel) >= NUM_SRC)) |-> !tick);
endmodule

// File: rtl/kfcd_gen.sv
module kfcd_gen
   import kfcd_pkg::*;
#(
   parameter int INT_W      = 12,
   parameter int FRAC_W     = 12,
   parameter bit HAS_SHAPER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              halt,
   input  shape_e            mode,
   input  logic [SEL_W-1:0]  src,
   input  logic [INT_W-1:0]  int_div,
   input  logic [FRAC_W-1:0] frac_div,
   input  logic              tick,
   output logic              busy,
   output logic              raw_out,
   output logic [SEL_W-1:0]  act_src
);
   localparam int PER_W = INT_W + 1;

   logic [INT_W-1:0]  act_int;
   logic [FRAC_W-1:0] act_frac;
   shape_e            act_mode;
   logic [PER_W-1:0]  cnt, per_len;
   logic [FRAC_W-1:0] acc;
   logic [FRAC_W:0]   acc_sum;
   logic              shaping, carry, start, wrap;

   function automatic logic [PER_W-1:0] eff_div(input logic [INT_W-1:0] d);
      return (d < INT_W'(2)) ? PER_W'(2) : {1'b0, d};
   endfunction

   if (HAS_SHAPER) begin : g_shaper
      assign shaping = (act_mode != SHP_NONE);
   end else begin : g_plain
      logic unused_mode;
      assign unused_mode = ^act_mode;
      assign shaping     = 1'b0;
   end

   assign acc_sum = {1'b0, acc} + {1'b0, act_frac};
   assign carry   = shaping & acc_sum[FRAC_W];
   assign start   = !busy && run && !halt;
   assign wrap    = busy && tick && (cnt == per_len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         per_len  <= PER_W'(2);
         acc      <= '0;
         act_int  <= '0;
         act_frac <= '0;
         act_mode <= SHP_NONE;
         act_src  <= '0;
      end else begin
         // configuration is sampled only while idle
         if (!busy) begin
            act_int  <= int_div;
            act_frac <= frac_div;
            act_mode <= mode;
            act_src  <= src;
         end
         if (halt) begin
            busy <= 1'b0;
            cnt  <= '0;
            acc  <= '0;
         end else if (start) begin
            busy    <= 1'b1;
            cnt     <= '0;
            acc     <= '0;
            per_len <= eff_div(int_div);
         end else if (wrap) begin
            cnt     <= '0;
            acc     <= acc_sum[FRAC_W-1:0];
            per_len <= eff_div(act_int) + PER_W'(carry);
            if (!run) busy <= 1'b0;
         end else if (busy && tick) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign raw_out = busy && (cnt < (per_len >> 1));

   // R9: halt drops busy on the following edge
   p_halt_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !busy);

   // R4: busy only rises after run was seen with halt clear
   p_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(run) && !$past(halt)));

   // R8: a graceful stop happens while the output is low
   p_clean_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(halt)) |-> !$past(raw_out));

   // R11: sampled configuration is frozen while running
   p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |->
         ($stable(act_int) && $stable(act_frac) && $stable(act_src) && $stable(act_mode)));

   // R7: a period is never shorter than two ticks
   p_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (per_len >= PER_W'(2)));

   // R5: integer-only mode never stretches a period, count stays in range
   p_int_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !shaping) |-> (per_len == eff_div(act_int)));
   p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < per_len));
endmodule

// File: rtl/keyed_frac_clkdiv.sv
module keyed_frac_clkdiv
   import kfcd_pkg::*;
#(
   parameter int         NUM_SRC    = 8,
   parameter int         INT_W      = 12,
   parameter int         FRAC_W     = 12,
   parameter bit         HAS_SHAPER = 1'b1,
   parameter logic [7:0] KEY        = WR_KEY
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_sel_div,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic               clk_out
);
   if (NUM_SRC < 2 || NUM_SRC > (1 << SEL_W)) begin : g_bad_nsrc
      $error("keyed_frac_clkdiv: NUM_SRC must be 2..16");
   end
   if (INT_W < 2 || INT_W > 12) begin : g_bad_int
      $error("keyed_frac_clkdiv: INT_W must be 2..12");
   end
   if (FRAC_W < 1 || FRAC_W > 12) begin : g_bad_frac
      $error("keyed_frac_clkdiv: FRAC_W must be 1..12");
   end

   ctrl_t             ctrl;
   logic [INT_W-1:0]  int_div;
   logic [FRAC_W-1:0] frac_div;
   logic              busy, raw_out, tick;
   logic [SEL_W-1:0]  act_src;

   kfcd_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .KEY(KEY)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_sel_div (bus_sel_div),
      .bus_wdata   (bus_wdata),
      .busy        (busy),
      .ctrl        (ctrl),
      .int_div     (int_div),
      .frac_div    (frac_div),
      .bus_rdata   (bus_rdata)
   );

   kfcd_srcsel #(.NUM_SRC(NUM_SRC)) u_srcsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .sel      (act_src),
      .tick     (tick)
   );

   kfcd_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W), .HAS_SHAPER(HAS_SHAPER)) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl.run),
      .halt     (ctrl.halt),
      .mode     (ctrl.mode),
      .src      (ctrl.src),
      .int_div  (int_div),
      .frac_div (frac_div),
      .tick     (tick),
      .busy     (busy),
      .raw_out  (raw_out),
      .act_src  (act_src)
   );

   // R12: inversion is applied after the stop logic, live from the register
   assign clk_out = raw_out ^ ctrl.inv;

   // R12: while stopped the pin shows only the invert setting
   p_idle_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (clk_out == ctrl.inv));
endmodule

// File: tb/keyed_frac_clkdiv_bench.sv
module keyed_frac_clkdiv_bench;
   localparam int NSRC = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0;
   logic            bus_sel_div = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NSRC-1:0] src_tick = '0;
   logic            clk_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   keyed_frac_clkdiv #(.NUM_SRC(NSRC)) u_keyed_frac_clkdiv (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_sel_div (bus_sel_div),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .src_tick    (src_tick),
      .clk_out     (clk_out)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // control word: key[31:24], mode[10:9], invert[8], halt[5], run[4], source[3:0]
   function automatic logic [31:0] cw(input logic [7:0] key, input int src, input bit run,
                                      input bit halt, input bit inv, input int mode);
      return {key, 13'd0, 2'(mode), inv, 1'b0, 1'b0, halt, run, 4'(src)};
   endfunction

   // divisor word: key[31:24], integer[23:12], fraction[11:0]
   function automatic logic [31:0] dw(input logic [7:0] key, input int d, input int f);
      return {key, 12'(d), 12'(f)};
   endfunction

   task automatic bus_write(input bit sel, input logic [31:0] d);
      bus_sel_div = sel;
      bus_wdata   = d;
      bus_wr      = 1'b1;
      @(negedge clk);
      bus_wr      = 1'b0;
      bus_sel_div = 1'b0;
   endtask

   task automatic bus_read(input bit sel, output logic [31:0] v);
      bus_sel_div = sel;
      #1;
      v = bus_rdata;
      bus_sel_div = 1'b0;
   endtask

   task automatic get_busy(output bit b);
      logic [31:0] v;
      bus_read(1'b0, v);
      b = v[7];
   endtask

   task automatic cycle_mask(input logic [NSRC-1:0] m);
      src_tick = m;
      @(negedge clk);
      src_tick = '0;
   endtask

   task automatic cycle(input int src, input bit t);
      logic [NSRC-1:0] m;
      m = '0;
      if (t && src < NSRC) m[src] = 1'b1;
      cycle_mask(m);
   endtask

   task automatic start_gen(input int src, input int d, input int f, input int mode, input bit inv);
      bit b;
      bus_write(1'b1, dw(8'h5A, d, f));
      bus_write(1'b0, cw(8'h5A, src, 1'b1, 1'b0, inv, mode));
      get_busy(b);
      check(b == 1'b0, "R4", "busy one cycle after run write", b, 0);
      cycle(src, 1'b0);
      get_busy(b);
      check(b == 1'b1, "R4", "busy two edges after run write", b, 1);
      check(clk_out == !inv, "R4", "output level at start", clk_out, !inv);
   endtask

   // measure nper periods from a fresh start, comparing with an accumulator model
   task automatic measure(input int src, input int d, input int f, input int mode, input int nper);
      int    deff, acc, k, cnt, exp_len, guard;
      bit    last, t;
      string req;
      deff    = (d < 2) ? 2 : d;
      acc     = 0;
      k       = 0;
      cnt     = 0;
      guard   = 0;
      exp_len = deff;
      last    = 1'b1;
      req     = (mode == 0) ? ((d < 2) ? "R7" : "R5") : "R6";
      while (k < nper && guard < 20000) begin
         t = ($urandom % 2) == 1;
         cycle(src, t);
         guard++;
         if (t) cnt++;
         if (last && !clk_out)
            check(cnt == exp_len / 2, req, "high-phase ticks", cnt, exp_len / 2);
         if (!last && clk_out) begin
            check(cnt == exp_len, req, "period ticks", cnt, exp_len);
            k++;
            cnt = 0;
            acc = acc + f;
            exp_len = (mode != 0 && acc >= 4096) ? deff + 1 : deff;
            acc = acc % 4096;
         end
         last = clk_out;
      end
      check(k == nper, req, "periods observed", k, nper);
   endtask

   task automatic stop_gen(input int src, input int mode);
      bit b;
      int guard;
      bus_write(1'b0, cw(8'h5A, src, 1'b0, 1'b0, 1'b0, mode));
      guard = 0;
      get_busy(b);
      while (b && guard < 300) begin
         cycle(src, ($urandom % 2) == 1);
         guard++;
         get_busy(b);
      end
      check(b == 1'b0, "R8", "busy cleared after graceful stop", b, 0);
      check(clk_out == 1'b0, "R8", "output low after graceful stop", clk_out, 0);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      bit          b, moved;
      void'($urandom(32'd7341));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      bus_read(1'b0, v);
      check(v == 32'h0, "R2", "control after reset", v, 0);
      bus_read(1'b1, v);
      check(v == 32'h0, "R3", "divisor after reset", v, 0);
      check(clk_out == 1'b0, "R12", "output after reset", clk_out, 0);

      // R1: wrong key is ignored
      bus_write(1'b1, dw(8'hA5, 5, 3));
      bus_read(1'b1, v);
      check(v == 32'h0, "R1", "divisor after unkeyed write", v, 0);
      bus_write(1'b0, cw(8'h5B, 2, 1'b1, 1'b0, 1'b1, 1));
      repeat (3) cycle(2, 1'b1);
      bus_read(1'b0, v);
      check(v == 32'h0, "R1", "control after unkeyed write", v, 0);
      check(clk_out == 1'b0, "R1", "no start after unkeyed write", clk_out, 0);

      // R3 / R2: field layout and read-only busy
      bus_write(1'b1, 32'h5AAB_C123);
      bus_read(1'b1, v);
      check(v == 32'h00AB_C123, "R3", "divisor readback", v, 32'h00AB_C123);
      bus_write(1'b0, 32'h5A7F_F4C3);
      bus_read(1'b0, v);
      check(v == 32'h0000_0403, "R2", "control readback mask", v, 32'h403);
      bus_write(1'b0, cw(8'h5A, 0, 1'b0, 1'b0, 1'b0, 0));

      // R5 then directed R8
      start_gen(2, 5, 0, 0, 1'b0);
      measure(2, 5, 0, 0, 6);
      bus_write(1'b0, cw(8'h5A, 2, 1'b0, 1'b0, 1'b0, 0));
      get_busy(b);
      check(b == 1'b1, "R8", "busy held after run cleared", b, 1);
      repeat (4) cycle(2, 1'b1);
      get_busy(b);
      check(b == 1'b1, "R8", "busy before period end", b, 1);
      check(clk_out == 1'b0, "R8", "output low late in period", clk_out, 0);
      cycle(2, 1'b1);
      get_busy(b);
      check(b == 1'b0, "R8", "busy falls at period end", b, 0);
      check(clk_out == 1'b0, "R8", "output low when stopped", clk_out, 0);

      // R11: changes while busy are deferred
      start_gen(1, 4, 0, 0, 1'b0);
      measure(1, 4, 0, 0, 2);
      bus_write(1'b1, dw(8'h5A, 7, 0));
      bus_write(1'b0, cw(8'h5A, 3, 1'b1, 1'b0, 1'b0, 0));
      bus_read(1'b1, v);
      check(v == 32'h0000_7000, "R11", "new divisor stored", v, 32'h7000);
      measure(1, 4, 0, 0, 4);
      stop_gen(1, 0);
      start_gen(3, 7, 0, 0, 1'b0);
      measure(3, 7, 0, 0, 3);
      stop_gen(3, 0);

      // R6: first-order shaping, mode 3 behaves as first order
      start_gen(4, 3, 12'h400, 1, 1'b0);
      measure(4, 3, 12'h400, 1, 10);
      stop_gen(4, 1);
      start_gen(4, 2, 12'hFFF, 3, 1'b0);
      measure(4, 2, 12'hFFF, 3, 8);
      stop_gen(4, 3);

      // R7: small divisors clamp to 2
      start_gen(1, 1, 0, 0, 1'b0);
      measure(1, 1, 0, 0, 4);
      stop_gen(1, 0);
      start_gen(1, 0, 0, 0, 1'b0);
      measure(1, 0, 0, 0, 4);
      stop_gen(1, 0);

      // R10: only the selected strobe counts
      start_gen(5, 3, 0, 0, 1'b0);
      moved = 1'b0;
      for (int i = 0; i < 20; i++) begin
         cycle(6, 1'b1);
         if (clk_out != 1'b1) moved = 1'b1;
      end
      check(moved == 1'b0, "R10", "unselected source ignored", moved, 0);
      stop_gen(5, 0);

      // R10 / R9: ground source never ticks, halt is required
      start_gen(0, 3, 0, 0, 1'b0);
      moved = 1'b0;
      for (int i = 0; i < 30; i++) begin
         cycle_mask('1);
         if (clk_out != 1'b1) moved = 1'b1;
      end
      check(moved == 1'b0, "R10", "ground source never advances", moved, 0);
      bus_write(1'b0, cw(8'h5A, 0, 1'b0, 1'b0, 1'b0, 0));
      repeat (30) cycle_mask('1);
      get_busy(b);
      check(b == 1'b1, "R8", "stop waits for a period end", b, 1);
      bus_write(1'b0, cw(8'h5A, 0, 1'b0, 1'b1, 1'b0, 0));
      cycle(0, 1'b0);
      get_busy(b);
      check(b == 1'b0, "R9", "halt clears busy", b, 0);
      check(clk_out == 1'b0, "R9", "halt forces output low", clk_out, 0);
      bus_write(1'b0, cw(8'h5A, 1, 1'b1, 1'b1, 1'b0, 0));
      repeat (5) cycle(1, 1'b1);
      get_busy(b);
      check(b == 1'b0, "R9", "run blocked while halted", b, 0);
      check(clk_out == 1'b0, "R9", "output stays low while halted", clk_out, 0);
      bus_write(1'b0, cw(8'h5A, 0, 1'b0, 1'b0, 1'b0, 0));

      // R10: index beyond populated sources never ticks
      start_gen(9, 3, 0, 0, 1'b0);
      moved = 1'b0;
      for (int i = 0; i < 30; i++) begin
         cycle_mask('1);
         if (clk_out != 1'b1) moved = 1'b1;
      end
      check(moved == 1'b0, "R10", "unpopulated index never advances", moved, 0);
      bus_write(1'b0, cw(8'h5A, 9, 1'b0, 1'b1, 1'b0, 0));
      cycle(0, 1'b0);
      bus_write(1'b0, cw(8'h5A, 0, 1'b0, 1'b0, 1'b0, 0));

      // R12: invert is live
      bus_write(1'b0, cw(8'h5A, 1, 1'b0, 1'b0, 1'b1, 0));
      check(clk_out == 1'b1, "R12", "invert while stopped", clk_out, 1);
      start_gen(1, 2, 0, 0, 1'b1);
      cycle(1, 1'b1);
      check(clk_out == 1'b1, "R12", "inverted low phase", clk_out, 1);
      bus_write(1'b0, cw(8'h5A, 1, 1'b1, 1'b0, 1'b0, 0));
      check(clk_out == 1'b0, "R12", "invert cleared while running", clk_out, 0);
      stop_gen(1, 0);

      // constrained random configurations
      for (int it = 0; it < 12; it++) begin
         int s, d, f, m;
         s = 1 + ($urandom % (NSRC - 1));
         d = $urandom % 10;
         f = $urandom % 4096;
         m = $urandom % 4;
         start_gen(s, d, f, m, 1'b0);
         measure(s, d, f, m, 6);
         stop_gen(s, m);
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule